// File: doc/BRIEF.md
# Cascadable Decade Counter Stage

This block is one decimal digit of a counter. It holds a 4-bit value that steps 0, 1, ... 9 and then returns to 0. Several stages can be chained into a multi-digit decimal counter: the carry output of one digit drives the count enable of the next.

All state changes happen on the rising clock edge. An active-low synchronous reset forces the digit to zero. A synchronous clear also forces zero and takes priority over counting. With neither of them active, the count enable chooses between holding and advancing.

The carry flag is combinational. It is high only while counting is enabled and the digit shows nine, so the next digit advances on the same edge where this one wraps.

Top module: `decadeStage`

## Requirements
- R1: When `rstN` is 0 at a rising edge, `count` is 0 after that edge, whatever `enable` and `clear` are.
- R2: With `rstN`=1, `enable`=0 and `clear`=0, `count` keeps its value across a rising edge.
- R3: With `rstN`=1, `enable`=1 and `clear`=0, `count` grows by one at each rising edge while it is below 9.
- R4: With `rstN`=1, `enable`=1 and `clear`=0, a `count` of 9 becomes 0 at the rising edge.
- R5: With `rstN`=1, `enable`=0 and `clear`=1, `count` becomes 0 at the rising edge.
- R6: With `rstN`=1, `enable`=1 and `clear`=1, the clear wins and `count` becomes 0 at the rising edge.
- R7: `roll` is combinational and equals 1 exactly when `enable`=1 and `count`=9. It follows a change of `enable` without waiting for a clock edge.
- R8: `roll` is 0 whenever `enable`=0, including while `count`=9.
- R9: After a reset, `count` never takes a code from 10 to 15.
- R10: `count` changes only at a rising edge. An input change between edges leaves it unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Count enable |
| clear | input | 1 | Synchronous clear to zero, active high |
| count | output | 4 | Current digit value, binary 0 to 9 |
| roll | output | 1 | Carry to the next digit: enable and digit at nine |

## Verification
The stage is driven through several uninterrupted runs with the enable high. These runs cover every step from 0 to 9 and the 9-to-0 wrap, and they separate a correct modulus from one that wraps early or late.

Holds are tried with the enable low at an ordinary value and at nine. These tell a true hold from a drifting count, and a gated carry from an ungated one.

The clear is applied alone and together with the enable at mid-range values. This tells clear priority apart from increment priority. Reset is applied with every combination of enable and clear.

Finally, enable changes in the middle of a clock period. This shows that `roll` follows the change at once, while `count` waits for the next rising edge.

// File: rtl/decadePkg.sv
package decadePkg;
  // Strobes issued by control to the datapath each cycle
  typedef struct packed {
    logic loadZero;  // force the register to zero (reset or clear)
    logic doInc;     // advance with wrap
  } stepCtrl_t;
endpackage

// File: rtl/decadeCtrl.sv
module decadeCtrl
  import decadePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      clear,
  input  logic      isNine,
  output stepCtrl_t ctrl,
  output logic      roll
);
  // Priority: reset, then clear, then enable
  always_comb begin
    ctrl.loadZero = !rstN || clear;
    ctrl.doInc    = rstN && !clear && enable;
  end

  assign roll = enable && isNine;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> (ctrl.loadZero && !ctrl.doInc)); // R6
  AST_ROLL_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !roll); // R8
  AST_ROLL_AT_NINE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && isNine) |-> roll); // R7
endmodule

// File: rtl/decadeData.sv
module decadeData
  import decadePkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtrl_t        ctrl,
  output logic [CNT_W-1:0] count,
  output logic             isNine
);
  localparam logic [CNT_W-1:0] LAST_CODE = CNT_W'(MODULUS - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] incVal;
  logic [CNT_W-1:0] nextCount;

  // Comparator and adder with wrap
  assign isNine = (countQ == LAST_CODE);
  assign incVal = isNine ? '0 : countQ + ONE;

  // Three-way selector feeding the register
  always_comb begin
    if (ctrl.loadZero)   nextCount = '0;
    else if (ctrl.doInc) nextCount = incVal;
    else                 nextCount = countQ;
  end

  always_ff @(posedge clk) countQ <= nextCount;

  assign count = countQ;

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |=> (countQ == '0)); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.loadZero && !ctrl.doInc) |=> $stable(countQ)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doInc && !ctrl.loadZero && countQ != LAST_CODE) |=> (countQ == $past(countQ) + ONE)); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.doInc && !ctrl.loadZero && countQ == LAST_CODE) |=> (countQ == '0)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadZero |=> (countQ == '0)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= LAST_CODE); // R9
endmodule

// File: rtl/decadeStage.sv
module decadeStage
  import decadePkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             roll
);
  stepCtrl_t ctrl;
  logic      isNine;

  decadeCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .clear  (clear),
    .isNine (isNine),
    .ctrl   (ctrl),
    .roll   (roll)
  );

  decadeData #(.CNT_W(CNT_W), .MODULUS(MODULUS)) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .count  (count),
    .isNine (isNine)
  );
endmodule

// File: tb/test_decadeStage.sv
module test_decadeStage;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       clear = 1'b0;
  logic [3:0] count;
  logic       roll;
  int         total = 0;
  int         bad = 0;
  int         refCount = 0;

  always #10 clk = ~clk;  // 50 MHz

  decadeStage i_decadeStage (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear),
    .count(count), .roll(roll)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, check roll, clock once, check count.
  task automatic step(input logic r, input logic e, input logic c,
                      input string tagCnt, input string tagRoll);
    rstN = r; enable = e; clear = c;
    #1;
    check(tagRoll, int'(roll), (e && refCount == 9) ? 1 : 0);
    @(posedge clk);
    if (!r || c)  refCount = 0;
    else if (e)   refCount = (refCount + 1) % 10;
    @(negedge clk);
    check(tagCnt, int'(count), refCount);
  endtask

  task automatic testReset();
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b1, 1'b0, "R3", "R7");
      step(1'b0, k[0], k[1], "R1", "R7");
    end
  endtask

  task automatic testWraps();
    for (int k = 0; k < 30; k++)
      step(1'b1, 1'b1, 1'b0, (refCount == 9) ? "R4" : "R3", "R7");
    check("R9", (int'(count) <= 9) ? 1 : 0, 1);
  endtask

  task automatic testHold();
    while (refCount != 9) step(1'b1, 1'b1, 1'b0, "R3", "R7");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, "R2", "R8");
    step(1'b1, 1'b1, 1'b0, "R4", "R7");
    step(1'b1, 1'b1, 1'b0, "R3", "R7");
    step(1'b1, 1'b0, 1'b0, "R2", "R8");
  endtask

  task automatic testClear();
    while (refCount != 5) step(1'b1, 1'b1, 1'b0, "R3", "R7");
    step(1'b1, 1'b0, 1'b1, "R5", "R8");
    check("R5", int'(count), 0);
    while (refCount != 7) step(1'b1, 1'b1, 1'b0, "R3", "R7");
    step(1'b1, 1'b1, 1'b1, "R6", "R7");
    check("R6", int'(count), 0);
    while (refCount != 9) step(1'b1, 1'b1, 1'b0, "R3", "R7");
    step(1'b1, 1'b1, 1'b1, "R6", "R7");
  endtask

  task automatic testMidCycle();
    while (refCount != 9) step(1'b1, 1'b1, 1'b0, "R3", "R7");
    enable = 1'b0; #1;
    check("R8", int'(roll), 0);
    #4; enable = 1'b1; #1;
    check("R7", int'(roll), 1);
    #3;
    check("R10", int'(count), 9);
    @(posedge clk); refCount = 0; @(negedge clk);
    check("R4", int'(count), 0);
    enable = 1'b1; #8;
    check("R10", int'(count), 0);
    @(negedge clk); refCount = 1;
    check("R10", int'(count), 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    enable = 1'b1; clear = 1'b1; rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R1", int'(count), 0);
    refCount = 0;
    testReset();
    testWraps();
    testHold();
    testClear();
    testMidCycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule